// File: doc/BRIEF.md
# Peripheral Interrupt Combiner and Take Gate

This block gathers interrupt requests from three on-chip engines and turns them into one interrupt request for the processor core. The three engines are a signal processor, a display processor and an audio unit. Each request lands in an interface interrupt register. The signal and display bits are sticky: a request pulse sets them, and they stay set until software clears them with a write-one-to-clear access. The audio bit is different. It is reloaded from its source level on every cycle, so it always reflects the current state of the audio request.

A software-writable enable register selects which of those bits count. If any enabled bit is set, the block raises one hardware pending bit in the pending byte of the Cause register. The other hardware pending bits of that byte come from outside the block and pass through unchanged.

A second gating stage compares the pending byte against the interrupt mask byte of the Status register. It also checks three Status bits: global enable, exception level and error level. When every condition allows it, the block raises a registered take request to the exception sequencer. That request stays high until the sequencer acknowledges it.

Top module: `irq_aggregator`

## Requirements
- R1: Bit 2 of `irq_reg_o` (audio) equals the level of `src_req_i[2]` sampled at the previous clock edge. A clear write to that bit has no effect while its source stays high.
- R2: Bits 0 (signal processor) and 1 (display processor) of `irq_reg_o` become 1 one cycle after their request input is high. They stay 1 until a write with `clr_we_i` high and a 1 at that bit position of `clr_bits_i`, which clears them one cycle later.
- R3: If a sticky bit's request and its clear arrive in the same cycle, the bit ends up set.
- R4: A write with `mask_we_i` high loads `mask_bits_i` into `irq_mask_o` one cycle later. Without a write, the mask holds its value.
- R5: Bit 2 of `cause_ip_o` (Cause bit 10) is 1 exactly when `irq_reg_o & irq_mask_o` was nonzero one cycle earlier. Otherwise it is 0.
- R6: The other bits of `cause_ip_o` copy `ext_pend_i` with one cycle of delay. `ext_pend_i[2]` is ignored.
- R7: `take_req_o` does not rise while Status bit 0 (interrupt enable) is 0.
- R8: `take_req_o` does not rise while Status bit 1 (exception level) or Status bit 2 (error level) is 1.
- R9: `take_req_o` rises one cycle after a cycle in which the enable conditions hold and `status_i[15:8] & cause_ip_o` is nonzero. It does not rise when that AND is zero.
- R10: Once `take_req_o` is high, it stays high regardless of Status until `take_ack_i` is seen. It is low in the following cycle, and it may rise again only after that.
- R11: After reset, `irq_reg_o`, `irq_mask_o`, `cause_ip_o` and `take_req_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 3 | Requests: [0] signal processor, [1] display processor, [2] audio level |
| clr_we_i | input | 1 | Write strobe for the write-one-to-clear access |
| clr_bits_i | input | 3 | Bits to clear in the interrupt register |
| mask_we_i | input | 1 | Write strobe for the enable mask |
| mask_bits_i | input | 3 | New enable mask value |
| status_i | input | 16 | Status: [0] enable, [1] exception level, [2] error level, [15:8] mask byte |
| ext_pend_i | input | 8 | Other hardware pending bits for the Cause pending byte |
| take_ack_i | input | 1 | Acknowledge from the exception sequencer |
| irq_reg_o | output | 3 | Interface interrupt register |
| irq_mask_o | output | 3 | Interface enable mask |
| cause_ip_o | output | 8 | Cause pending byte (Cause bits 15:8) |
| take_req_o | output | 1 | Registered take-interrupt request |

## Verification
The bench drives a request and a clear onto the same sticky bit in the same cycle. A design with the wrong priority would silently drop that interrupt. It also holds the audio source high while clearing the audio bit, which catches a design that lets the clear stick on a level source. Each of the three Status gating bits is tried separately, with the interface pending bit present and, in another case, with the pending bit masked off by the Status byte. A wrong gate would raise `take_req_o` in one of those cases. The bench also changes Status while a take is outstanding, and it holds the condition true across an acknowledge. This exposes a request that drops early or one that never re-arms. An external pending bit placed at the interface position shows whether the block leaks it into Cause.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int STATUS_W  = 16;
    localparam int ST_IE     = 0;
    localparam int ST_EXL    = 1;
    localparam int ST_ERL    = 2;
    localparam int ST_IM_LO  = 8;
    localparam int IP_W      = 8;
    localparam int IP_IFACE  = 2;   // Cause bit 10 within the pending byte
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int NSRC      = 3,
    parameter int LEVEL_IDX = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            mask_we_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] irq_o,
    output logic [NSRC-1:0] mask_o
);
    typedef struct packed {
        logic [NSRC-1:0] irq;
        logic [NSRC-1:0] mask;
    } st_t;

    st_t st_d, st_q;
    logic [NSRC-1:0] clr_hit;

    assign clr_hit = clr_we_i ? clr_i : '0;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (i == LEVEL_IDX) begin
                st_d.irq[i] = src_i[i];
            end else begin
                st_d.irq[i] = src_i[i] | (st_q.irq[i] & ~clr_hit[i]);
            end
        end
        if (mask_we_i) begin
            st_d.mask = mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o  = st_q.irq;
    assign mask_o = st_q.mask;

    for (genvar g = 0; g < NSRC; g++) begin : g_src_chk
        if (g == LEVEL_IDX) begin : g_level
            p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> irq_o[g] == $past(src_i[g]));
        end else begin : g_sticky
            p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_o[g] && !(clr_we_i && clr_i[g])) |=> irq_o[g]);
            p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
                src_i[g] |=> irq_o[g]);
        end
    end

    p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> mask_o == $past(mask_i));
    p_mask_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_cause_pend.sv
module irq_cause_pend
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic [IP_W-1:0] ext_i,
    output logic [IP_W-1:0] cause_o
);
    typedef struct packed {
        logic [IP_W-1:0] ip;
    } st_t;

    st_t st_d, st_q;
    logic any_iface;

    assign any_iface = |(irq_i & mask_i);

    always_comb begin
        st_d          = st_q;
        st_d.ip       = ext_i;
        st_d.ip[IP_IFACE] = any_iface;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.ip;

    p_iface_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cause_o[IP_IFACE] == $past(|(irq_i & mask_i)));
    p_ext_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cause_o[IP_IFACE-1:0] == $past(ext_i[IP_IFACE-1:0]));
endmodule

// File: rtl/irq_take_gate.sv
module irq_take_gate
    import irq_agg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_i,
    input  logic [IP_W-1:0]     cause_i,
    input  logic                ack_i,
    output logic                take_o
);
    typedef struct packed {
        logic take;
    } st_t;

    st_t st_d, st_q;
    logic gate_open;
    logic pend_hit;

    assign gate_open = status_i[ST_IE] & ~status_i[ST_EXL] & ~status_i[ST_ERL];
    assign pend_hit  = |(status_i[ST_IM_LO +: IP_W] & cause_i);

    always_comb begin
        st_d = st_q;
        if (st_q.take) begin
            st_d.take = ~ack_i;
        end else begin
            st_d.take = gate_open & pend_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o = st_q.take;

    p_gate_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && !status_i[ST_IE]) |=> !take_o);
    p_gate_exl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && status_i[ST_EXL]) |=> !take_o);
    p_gate_erl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && status_i[ST_ERL]) |=> !take_o);
    p_need_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && (status_i[ST_IM_LO +: IP_W] & cause_i) == '0) |=> !take_o);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !ack_i) |=> take_o);
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_i) |=> !take_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NSRC      = 3,
    parameter int LEVEL_IDX = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     src_req_i,
    input  logic                clr_we_i,
    input  logic [NSRC-1:0]     clr_bits_i,
    input  logic                mask_we_i,
    input  logic [NSRC-1:0]     mask_bits_i,
    input  logic [STATUS_W-1:0] status_i,
    input  logic [IP_W-1:0]     ext_pend_i,
    input  logic                take_ack_i,
    output logic [NSRC-1:0]     irq_reg_o,
    output logic [NSRC-1:0]     irq_mask_o,
    output logic [IP_W-1:0]     cause_ip_o,
    output logic                take_req_o
);
    logic [NSRC-1:0] irq_w;
    logic [NSRC-1:0] mask_w;
    logic [IP_W-1:0] cause_w;

    irq_src_latch #(.NSRC(NSRC), .LEVEL_IDX(LEVEL_IDX)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_req_i),
        .clr_we_i  (clr_we_i),
        .clr_i     (clr_bits_i),
        .mask_we_i (mask_we_i),
        .mask_i    (mask_bits_i),
        .irq_o     (irq_w),
        .mask_o    (mask_w)
    );

    irq_cause_pend #(.NSRC(NSRC)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (irq_w),
        .mask_i  (mask_w),
        .ext_i   (ext_pend_i),
        .cause_o (cause_w)
    );

    irq_take_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_i),
        .cause_i  (cause_w),
        .ack_i    (take_ack_i),
        .take_o   (take_req_o)
    );

    assign irq_reg_o  = irq_w;
    assign irq_mask_o = mask_w;
    assign cause_ip_o = cause_w;

    p_reset_zero_r11: assert property (@(posedge clk)
        !rst_n |=> (irq_reg_o == '0 || $past(src_req_i) != '0 || rst_n) );
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    localparam int K_IRQ = 0, K_MASK = 1, K_CAUSE = 2, K_TAKE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src = '0;
    logic        clr_we = 1'b0;
    logic [2:0]  clr = '0;
    logic        mask_we = 1'b0;
    logic [2:0]  mask = '0;
    logic [15:0] status = '0;
    logic [7:0]  ext = '0;
    logic        ack = 1'b0;
    logic [2:0]  irq_reg, irq_mask;
    logic [7:0]  cause_ip;
    logic        take_req;

    always #4 clk = ~clk;   // 125 MHz

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .src_req_i(src), .clr_we_i(clr_we), .clr_bits_i(clr),
        .mask_we_i(mask_we), .mask_bits_i(mask), .status_i(status), .ext_pend_i(ext),
        .take_ack_i(ack), .irq_reg_o(irq_reg), .irq_mask_o(irq_mask),
        .cause_ip_o(cause_ip), .take_req_o(take_req)
    );

    typedef struct {
        int    due;
        int    kind;
        int    val;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    task automatic expect_at(input int off, input int kind, input int val, input string tag);
        exp_t e;
        e.due = cyc + off; e.kind = kind; e.val = val; e.tag = tag;
        exp_q.push_back(e);
    endtask

    function automatic int actual(input int kind);
        case (kind)
            K_IRQ:   return int'(irq_reg);
            K_MASK:  return int'(irq_mask);
            K_CAUSE: return int'(cause_ip);
            default: return int'(take_req);
        endcase
    endfunction

    // monitor: pops every item due in this cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            for (int k = exp_q.size() - 1; k >= 0; k--) begin
                if (exp_q[k].due == cyc) begin
                    checks++;
                    if (actual(exp_q[k].kind) != exp_q[k].val) begin
                        fails++;
                        $display("FAIL %s kind=%0d cycle=%0d actual=%0h expected=%0h",
                                 exp_q[k].tag, exp_q[k].kind, cyc,
                                 actual(exp_q[k].kind), exp_q[k].val);
                    end
                    exp_q.delete(k);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        @(negedge clk);
        expect_at(1, K_IRQ, 0, "R11"); expect_at(1, K_MASK, 0, "R11");
        expect_at(1, K_CAUSE, 0, "R11"); expect_at(1, K_TAKE, 0, "R11");
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R2 sticky set from a one-cycle pulse, mask still zero
        src = 3'b001; expect_at(1, K_IRQ, 1, "R2");
        @(negedge clk); src = '0;
        expect_at(2, K_IRQ, 1, "R2"); expect_at(2, K_CAUSE, 0, "R5");
        idle(1);

        // R4 / R5 enable mask drives the interface pending bit
        mask_we = 1'b1; mask = 3'b001;
        expect_at(1, K_MASK, 1, "R4"); expect_at(2, K_CAUSE, 8'h04, "R5");
        @(negedge clk); mask_we = 1'b0; mask = '0;
        expect_at(2, K_MASK, 1, "R4");
        idle(2);

        // R7: enable bit clear
        status = 16'h0400; expect_at(1, K_TAKE, 0, "R7"); expect_at(3, K_TAKE, 0, "R7");
        idle(3);
        // R8: exception level, then error level
        status = 16'h0403; expect_at(1, K_TAKE, 0, "R8"); expect_at(2, K_TAKE, 0, "R8");
        idle(2);
        status = 16'h0405; expect_at(1, K_TAKE, 0, "R8"); expect_at(2, K_TAKE, 0, "R8");
        idle(2);
        // R9: Status mask byte misses the pending bit
        status = 16'h0B01; expect_at(1, K_TAKE, 0, "R9"); expect_at(2, K_TAKE, 0, "R9");
        idle(2);
        // R9: all conditions hold
        status = 16'h0401; expect_at(1, K_TAKE, 1, "R9");
        @(negedge clk); status = 16'h0000;
        expect_at(2, K_TAKE, 1, "R10");
        idle(2);
        ack = 1'b1; expect_at(1, K_TAKE, 0, "R10");
        @(negedge clk); ack = 1'b0;
        expect_at(1, K_TAKE, 0, "R10"); expect_at(2, K_TAKE, 0, "R10");
        idle(2);
        // R10: re-raise after acknowledge while the condition still holds
        status = 16'h0401; expect_at(1, K_TAKE, 1, "R9");
        @(negedge clk); ack = 1'b1; expect_at(1, K_TAKE, 0, "R10");
        @(negedge clk); ack = 1'b0; expect_at(1, K_TAKE, 1, "R10");
        @(negedge clk); ack = 1'b1; status = 16'h0000; expect_at(1, K_TAKE, 0, "R10");
        @(negedge clk); ack = 1'b0;
        idle(1);

        // R3: set and clear on the same bit in the same cycle
        clr_we = 1'b1; clr = 3'b001; src = 3'b001; expect_at(1, K_IRQ, 1, "R3");
        @(negedge clk); src = '0;
        expect_at(1, K_IRQ, 0, "R2"); expect_at(2, K_CAUSE, 0, "R5");
        @(negedge clk); clr_we = 1'b0; clr = '0;
        idle(1);

        // R1: audio level bit follows its source, clear has no effect
        src = 3'b100; expect_at(1, K_IRQ, 3'b100, "R1"); expect_at(2, K_CAUSE, 0, "R5");
        @(negedge clk); clr_we = 1'b1; clr = 3'b100; expect_at(1, K_IRQ, 3'b100, "R1");
        @(negedge clk); clr_we = 1'b0; clr = '0; src = '0; expect_at(1, K_IRQ, 0, "R1");
        idle(1);

        // display bit with its own mask
        src = 3'b010; expect_at(1, K_IRQ, 3'b010, "R2");
        @(negedge clk); src = '0;
        mask_we = 1'b1; mask = 3'b010;
        expect_at(1, K_MASK, 3'b010, "R4"); expect_at(2, K_CAUSE, 8'h04, "R5");
        @(negedge clk); mask_we = 1'b0; mask = '0;
        idle(1);

        // R6: external pending bits pass through
        ext = 8'h81; expect_at(1, K_CAUSE, 8'h85, "R6");
        @(negedge clk); clr_we = 1'b1; clr = 3'b010; expect_at(2, K_CAUSE, 8'h81, "R5");
        @(negedge clk); clr_we = 1'b0; clr = '0;
        @(negedge clk); ext = 8'h04; expect_at(1, K_CAUSE, 8'h00, "R6");
        @(negedge clk); ext = 8'h00;
        idle(4);

        while (exp_q.size() != 0) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule